// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm

This block is a real-time-clock peripheral that sits on a simple register bus made of an address, a write strobe, write data and combinational read data. It keeps a 32-bit count of seconds that advances on a single-cycle 1 Hz tick input and compares that count with a 32-bit alarm value. Two sticky event flags record the per-second advance and an alarm match. A level interrupt output is raised when a flag is set and its enable bit is set.

Every register write goes through a ready handshake. A write is taken only while the ready status bit reads 1. The block then holds ready low for a fixed number of clock cycles. The new value becomes visible in the cycle that ready returns to 1, and writes made during that window are dropped. Software clears an event flag by writing 0 to it. Writing 1 to a flag leaves it unchanged, so a read-modify-write of the control register cannot lose a pending event.

The block also holds a power-down request register, a general 32-bit scratch register that software may use to recognise a clock that has already been set up, and a 32-bit trim storage word with no function attached.

Top module: `sec_rtc_top`

## Requirements
- R1: After reset the control register reads 0x80, meaning only the ready bit (bit 7) is 1. Every other register reads 0, and `irq_o` and `pwrdn_req_o` are 0.
- R2: The registers sit at these byte addresses: control 0x00, seconds 0x04, alarm 0x08, trim 0x0C, power-down 0x20 and scratch 0x34. Alarm, trim and scratch are plain 32-bit read/write storage. A read of any other address returns 0, and a write to any other address changes nothing.
- R3: A write is taken only when `bus_wr` is high while ready is 1. Ready (control bit 7) then reads 0 for exactly 4 clock cycles. The written register keeps its old value until ready reads 1 again, and holds the new value from then on.
- R4: A write issued while ready is 0 is ignored.
- R5: The control register reads back these enables: counter enable (bit 0), alarm enable (bit 2), alarm interrupt enable (bit 3) and per-second interrupt enable (bit 5). Bit 7 is read-only, and bits 1 and 8 to 31 read 0.
- R6: Software can load the seconds register. The count rises by one on each clock cycle in which `tick_1hz` is high and counter enable is 1. If counter enable is 0, ticks are ignored.
- R7: The seconds count goes from 0xFFFFFFFF to 0 on the next counted tick.
- R8: The per-second flag (control bit 6) is set by every increment of the seconds count.
- R9: The alarm flag (control bit 4) is set one cycle after the seconds count equals the alarm register while alarm enable is 1. If a set condition and a clearing write fall in the same cycle, the set wins.
- R10: When a control write takes effect, a 0 in bit 6 or bit 4 clears that flag and a 1 leaves it unchanged.
- R11: `irq_o` is 1 exactly when (the per-second flag AND its enable) OR (the alarm flag AND its enable) is true.
- R12: Bit 0 of the power-down register reads back and drives `pwrdn_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | Single-cycle pulse, once per second |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level interrupt request |
| pwrdn_req_o | output | 1 | Power-down request |

## Verification
A pending write that commits too early or too late appears straight away at the ports. It shows as a wrong count of cycles with ready low, or as a register read that changes before ready returns. A wrong seconds or flag state shows up at the next read of the control or seconds register. It also shows on `irq_o` in the same cycle when the matching enable is set. An alarm compare error shows one cycle after the count reaches the alarm value, and a wrap error shows on the first counted tick after 0xFFFFFFFF.

// File: rtl/sec_rtc_pkg.sv
`timescale 1ns/1ps
package sec_rtc_pkg;
  localparam int unsigned DW = 32;

  // register byte offsets
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_SEC   = 8'h04;
  localparam logic [7:0] OFS_ALM   = 8'h08;
  localparam logic [7:0] OFS_TRIM  = 8'h0C;
  localparam logic [7:0] OFS_PWRDN = 8'h20;
  localparam logic [7:0] OFS_SCR   = 8'h34;

  // control bit positions
  localparam int unsigned B_RDY    = 7;
  localparam int unsigned B_F1HZ   = 6;
  localparam int unsigned B_IE1HZ  = 5;
  localparam int unsigned B_FALM   = 4;
  localparam int unsigned B_IEALM  = 3;
  localparam int unsigned B_ALMEN  = 2;
  localparam int unsigned B_CNTEN  = 0;

  typedef struct packed {
    logic ie_1hz;
    logic ie_alm;
    logic alm_en;
    logic cnt_en;
  } ctrl_cfg_t;

  typedef struct packed {
    logic ctrl;
    logic sec;
    logic pwrdn;
  } sel_t;

  function automatic logic [DW-1:0] sec_advance(input logic [DW-1:0] s);
    return s + DW'(1);
  endfunction

  // sticky flag: set wins, a written 0 clears, a written 1 holds
  function automatic logic flag_update(input logic cur, input logic set_ev,
                                       input logic wr, input logic wbit);
    return set_ev | (cur & ~(wr & ~wbit));
  endfunction

  function automatic logic [DW-1:0] ctrl_image(input ctrl_cfg_t c, input logic rdy,
                                               input logic f1, input logic fa);
    logic [DW-1:0] v;
    v = '0;
    v[B_RDY]   = rdy;
    v[B_F1HZ]  = f1;
    v[B_IE1HZ] = c.ie_1hz;
    v[B_FALM]  = fa;
    v[B_IEALM] = c.ie_alm;
    v[B_ALMEN] = c.alm_en;
    v[B_CNTEN] = c.cnt_en;
    return v;
  endfunction

  function automatic logic irq_level(input ctrl_cfg_t c, input logic f1, input logic fa);
    return (f1 & c.ie_1hz) | (fa & c.ie_alm);
  endfunction
endpackage

// File: rtl/sec_rtc_wr_gate.sv
`timescale 1ns/1ps
module sec_rtc_wr_gate #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              accept_o,
  output logic              commit_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic [DATA_W-1:0] pdata_o
);
  localparam int unsigned CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] busy_cnt;

  assign ready_o  = (busy_cnt == '0);
  assign accept_o = wr_i & ready_o;
  assign commit_o = (busy_cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      paddr_o  <= '0;
      pdata_o  <= '0;
    end else if (accept_o) begin
      busy_cnt <= CW'(BUSY_CYCLES);
      paddr_o  <= addr_i;
      pdata_o  <= wdata_i;
    end else if (busy_cnt != '0) begin
      busy_cnt <= busy_cnt - CW'(1);
    end
  end
endmodule

// File: rtl/sec_rtc_store.sv
`timescale 1ns/1ps
module sec_rtc_store #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREG   = 3,
  parameter logic [NREG*8-1:0] OFS_LIST = {8'h34, 8'h0C, 8'h08}
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit_i,
  input  logic [ADDR_W-1:0]      paddr_i,
  input  logic [DATA_W-1:0]      pdata_i,
  output logic [NREG*DATA_W-1:0] regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = commit_i & (paddr_i == ADDR_W'(OFS_LIST[g*8 +: 8]));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs_o[g*DATA_W +: DATA_W] <= '0;
      else if (hit) regs_o[g*DATA_W +: DATA_W] <= pdata_i;
    end
  end
endmodule

// File: rtl/sec_rtc_core.sv
`timescale 1ns/1ps
module sec_rtc_core
  import sec_rtc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  ctrl_cfg_t     cfg_i,
  input  logic [DW-1:0] alarm_i,
  input  logic          ld_sec_i,
  input  logic          ld_ctrl_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] sec_o,
  output logic          f1hz_o,
  output logic          falm_o,
  output logic          inc_o,
  output logic          match_o
);
  // a software load of the count takes precedence over a tick
  assign inc_o   = tick_i & cfg_i.cnt_en & ~ld_sec_i;
  assign match_o = cfg_i.alm_en & (sec_o == alarm_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_o  <= '0;
      f1hz_o <= 1'b0;
      falm_o <= 1'b0;
    end else begin
      if (ld_sec_i)   sec_o <= wdata_i;
      else if (inc_o) sec_o <= sec_advance(sec_o);
      f1hz_o <= flag_update(f1hz_o, inc_o,   ld_ctrl_i, wdata_i[B_F1HZ]);
      falm_o <= flag_update(falm_o, match_o, ld_ctrl_i, wdata_i[B_FALM]);
    end
  end
endmodule

// File: rtl/sec_rtc_top.sv
`timescale 1ns/1ps
module sec_rtc_top
  import sec_rtc_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1hz,
  input  logic [7:0]    bus_addr,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq_o,
  output logic          pwrdn_req_o
);
  localparam int unsigned AW   = 8;
  localparam int unsigned NREG = 3;

  logic          wr_ready, wr_accept, commit;
  logic [AW-1:0] paddr;
  logic [DW-1:0] pdata;
  sel_t          sel;
  ctrl_cfg_t     cfg;
  logic [DW-1:0] seconds;
  logic          flag_1hz, flag_alm, inc_evt, match_evt;
  logic [NREG*DW-1:0] plain;
  logic [DW-1:0] alarm_val, trim_val, scr_val;
  logic          pwrdn_q;

  sec_rtc_wr_gate #(.ADDR_W(AW), .DATA_W(DW), .BUSY_CYCLES(BUSY_CYCLES)) u_gate (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .ready_o(wr_ready), .accept_o(wr_accept), .commit_o(commit),
    .paddr_o(paddr), .pdata_o(pdata)
  );

  assign sel.ctrl  = commit & (paddr == OFS_CTRL);
  assign sel.sec   = commit & (paddr == OFS_SEC);
  assign sel.pwrdn = commit & (paddr == OFS_PWRDN);

  sec_rtc_store #(.ADDR_W(AW), .DATA_W(DW), .NREG(NREG),
                  .OFS_LIST({OFS_SCR, OFS_TRIM, OFS_ALM})) u_store (
    .clk(clk), .rst_n(rst_n), .commit_i(commit), .paddr_i(paddr),
    .pdata_i(pdata), .regs_o(plain)
  );
  assign alarm_val = plain[0*DW +: DW];
  assign trim_val  = plain[1*DW +: DW];
  assign scr_val   = plain[2*DW +: DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= '0;
      pwrdn_q <= 1'b0;
    end else begin
      if (sel.ctrl) begin
        cfg.ie_1hz <= pdata[B_IE1HZ];
        cfg.ie_alm <= pdata[B_IEALM];
        cfg.alm_en <= pdata[B_ALMEN];
        cfg.cnt_en <= pdata[B_CNTEN];
      end
      if (sel.pwrdn) pwrdn_q <= pdata[0];
    end
  end

  sec_rtc_core u_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_1hz), .cfg_i(cfg), .alarm_i(alarm_val),
    .ld_sec_i(sel.sec), .ld_ctrl_i(sel.ctrl), .wdata_i(pdata),
    .sec_o(seconds), .f1hz_o(flag_1hz), .falm_o(flag_alm),
    .inc_o(inc_evt), .match_o(match_evt)
  );

  always_comb begin
    unique case (bus_addr)
      OFS_CTRL:  bus_rdata = ctrl_image(cfg, wr_ready, flag_1hz, flag_alm);
      OFS_SEC:   bus_rdata = seconds;
      OFS_ALM:   bus_rdata = alarm_val;
      OFS_TRIM:  bus_rdata = trim_val;
      OFS_PWRDN: bus_rdata = {{(DW-1){1'b0}}, pwrdn_q};
      OFS_SCR:   bus_rdata = scr_val;
      default:   bus_rdata = '0;
    endcase
  end

  assign irq_o       = irq_level(cfg, flag_1hz, flag_alm);
  assign pwrdn_req_o = pwrdn_q;
endmodule

// File: rtl/sec_rtc_chk.sv
`timescale 1ns/1ps
module sec_rtc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        wr_ready,
  input logic        commit,
  input logic        ld_sec,
  input logic        ld_pwrdn,
  input logic        pdata0,
  input logic        inc_evt,
  input logic        match_evt,
  input logic [31:0] seconds,
  input logic        flag_1hz,
  input logic        flag_alm,
  input logic        ie_alm,
  input logic        ie_1hz,
  input logic        irq_o,
  input logic        pwrdn_req_o
);
  // R3
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && wr_ready |=> !wr_ready);
  // R3
  commit_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> wr_ready);
  // R6
  count_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_evt && !ld_sec |=> $stable(seconds));
  // R7
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_evt && (seconds == 32'hFFFF_FFFF) |=> seconds == 32'h0);
  // R8
  tick_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_evt |=> flag_1hz);
  // R9
  match_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> flag_alm);
  // R11
  alarm_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_alm && ie_alm |-> irq_o);
  // R11
  sec_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_alm && ie_alm) && !(flag_1hz && ie_1hz) |-> !irq_o);
  // R12
  pwrdn_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pwrdn |=> pwrdn_req_o == $past(pdata0));
endmodule

bind sec_rtc_top sec_rtc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .wr_ready(wr_ready),
  .commit(commit), .ld_sec(sel.sec), .ld_pwrdn(sel.pwrdn), .pdata0(pdata[0]),
  .inc_evt(inc_evt), .match_evt(match_evt), .seconds(seconds),
  .flag_1hz(flag_1hz), .flag_alm(flag_alm), .ie_alm(cfg.ie_alm),
  .ie_1hz(cfg.ie_1hz), .irq_o(irq_o), .pwrdn_req_o(pwrdn_req_o)
);

// File: tb/test_sec_rtc_top.sv
`timescale 1ns/1ps
module test_sec_rtc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1hz = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        irq_o, pwrdn_req_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sec_rtc_top i_sec_rtc_top (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .pwrdn_req_o(pwrdn_req_o)
  );

  // control image model: rdy b7, f1 b6, ie1 b5, fa b4, iea b3, ae b2, en b0
  function automatic logic [31:0] ctl(input bit rdy, input bit f1, input bit ie1,
                                      input bit fa, input bit iea, input bit ae, input bit en);
    return (32'(rdy) << 7) | (32'(f1) << 6) | (32'(ie1) << 5) | (32'(fa) << 4)
         | (32'(iea) << 3) | (32'(ae) << 2) | 32'(en);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic wait_ready();
    bus_addr = 8'h00;
    #1;
    while (bus_rdata[7] !== 1'b1) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wait_ready();
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    wait_ready();
  endtask

  task automatic tick();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int busy;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, v); chk("R1 ctrl", v, 32'h80);
    rd(8'h04, v); chk("R1 sec", v, 0);
    rd(8'h34, v); chk("R1 scratch", v, 0);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 pwrdn", 32'(pwrdn_req_o), 0);

    // R3 busy window and late visibility
    wr(8'h34, 32'hA5A5_0001);
    @(negedge clk);
    bus_addr = 8'h34; bus_wdata = 32'h0000_BEEF; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    #1 chk("R3 old value during busy", bus_rdata, 32'hA5A5_0001);
    // R4 second write during busy
    bus_wr = 1'b1; bus_wdata = 32'h1234_0000;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_addr = 8'h00;
    busy = 1;
    #1;
    while (bus_rdata[7] == 1'b0) begin busy++; @(negedge clk); #1; end
    chk("R3 ready low cycles", 32'(busy), 4);
    rd(8'h34, v); chk("R3 new value", v, 32'h0000_BEEF);
    chk("R4 busy write dropped", v, 32'h0000_BEEF);

    // R2 unmapped
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, v); chk("R2 unmapped read", v, 0);
    rd(8'h10, v); chk("R2 unmapped read 0x10", v, 0);
    rd(8'h34, v); chk("R2 unmapped write no effect", v, 32'h0000_BEEF);

    // R2 random storage
    for (int i = 0; i < 24; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      int k;
      k = $urandom % 3;
      a = (k == 0) ? 8'h08 : (k == 1) ? 8'h0C : 8'h34;
      d = $urandom;
      wr(a, d);
      rd(a, v); chk("R2 storage", v, d);
    end

    // R5 control read-back, upper bits ignored
    wr(8'h00, 32'hFFFF_FF2C);
    rd(8'h00, v); chk("R5 ctrl image", v, ctl(1, 0, 1, 0, 1, 1, 0));
    wr(8'h00, 32'h0);

    // R6 load and count
    wr(8'h04, 32'h100);
    repeat (2) tick();
    rd(8'h04, v); chk("R6 disabled ticks ignored", v, 32'h100);
    wr(8'h00, ctl(0, 0, 0, 0, 0, 0, 1));
    repeat (3) tick();
    rd(8'h04, v); chk("R6 count", v, 32'h103);
    // R8
    rd(8'h00, v); chk("R8 1Hz flag", v, ctl(1, 1, 0, 0, 0, 0, 1));
    chk("R11 no irq without enable", 32'(irq_o), 0);
    // R10 write 1 keeps, write 0 clears
    wr(8'h00, ctl(0, 1, 1, 0, 0, 0, 1));
    rd(8'h00, v); chk("R10 keep with 1", v, ctl(1, 1, 1, 0, 0, 0, 1));
    chk("R11 1Hz irq", 32'(irq_o), 1);
    wr(8'h00, ctl(0, 0, 1, 0, 0, 0, 1));
    rd(8'h00, v); chk("R10 clear with 0", v, ctl(1, 0, 1, 0, 0, 0, 1));
    chk("R11 irq drop", 32'(irq_o), 0);

    // R7 wrap
    wr(8'h04, 32'hFFFF_FFFF);
    tick();
    rd(8'h04, v); chk("R7 wrap", v, 0);

    // R9 alarm
    wr(8'h00, ctl(0, 0, 0, 0, 1, 1, 1));
    wr(8'h08, 32'h10);
    wr(8'h04, 32'h0E);
    tick();
    @(negedge clk);
    rd(8'h00, v); chk("R9 no early alarm", v & 32'h10, 0);
    chk("R11 no alarm irq yet", 32'(irq_o), 0);
    tick();
    @(negedge clk);
    rd(8'h00, v); chk("R9 alarm flag", v, ctl(1, 1, 0, 1, 1, 1, 1));
    chk("R11 alarm irq", 32'(irq_o), 1);
    // R9 set beats clear while still matching
    wr(8'h00, ctl(0, 1, 0, 0, 1, 1, 1));
    rd(8'h00, v); chk("R9 set wins", v & 32'h10, 32'h10);
    wr(8'h00, ctl(0, 1, 0, 1, 1, 0, 1));
    wr(8'h00, ctl(0, 1, 0, 0, 1, 0, 1));
    rd(8'h00, v); chk("R10 alarm clear", v & 32'h10, 0);
    chk("R11 alarm irq cleared", 32'(irq_o), 0);

    // R12 power-down
    wr(8'h20, 32'h1);
    @(negedge clk);
    chk("R12 pwrdn high", 32'(pwrdn_req_o), 1);
    rd(8'h20, v); chk("R12 readback", v, 1);
    wr(8'h20, 32'h0);
    @(negedge clk);
    chk("R12 pwrdn low", 32'(pwrdn_req_o), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
  end
endmodule